// File: doc/BRIEF.md
# Timer Channel Control and Interrupt Register Bank

This block holds the shared control state for a group of timer channels and exposes it on a simple 32-bit register bus. It keeps four bit vectors:

- a per-channel run/halt vector, driven out as `stop_o`;
- a per-channel enable vector, driven out as `enable_o`;
- a 32-bit interrupt flag word;
- a 32-bit interrupt mask word.

Each vector can be reached in three ways: a load address, a write-one-to-set alias and a write-one-to-clear alias. Software can change single channels through the aliases without a read-modify-write.

The channel counters are outside this block. Each channel sends two pulses into it: a full-compare event and a half-compare event. A full-compare event sets bit n of the flag word and a half-compare event sets bit n+16. The mask word uses the same bit layout. The block ORs every flag bit whose mask bit is clear and registers the result as a single interrupt line.

Reads are combinational: `rdata_o` is valid in the same cycle as a read request. Writes take effect at the next clock edge.

Top module: `tmr_ctl_regs`

## Requirements
- R1: After reset, enable and flag are all zero. Stop is all ones on the implemented channels (0xFF for 8 channels). Mask is all ones on the implemented bits (0x00FF00FF for 8 channels). `irq_o` is 0.
- R2: The load addresses are: enable at 0x00, stop at 0x0C, flag at 0x10 and mask at 0x20. A write to a load address replaces the vector with the written data, restricted to the implemented bits.
- R3: The set aliases are: enable at 0x04, stop at 0x1C, flag at 0x14 and mask at 0x24. Writing to a set alias sets every bit written as 1 and leaves bits written as 0 unchanged.
- R4: The clear aliases are: enable at 0x08, stop at 0x2C, flag at 0x18 and mask at 0x28. Writing to a clear alias clears every bit written as 1 and leaves bits written as 0 unchanged.
- R5: Reading any of a vector's three addresses returns its current value. Reading an unmapped address returns 0. Reads change no state, and writes to unmapped addresses change no state.
- R6: A full-compare pulse on channel n sets flag bit n at the next edge. A half-compare pulse on channel n sets flag bit n+16 at the next edge.
- R7: When a hardware event and a software write (clear alias or load) target the same flag bit in the same cycle, the bit ends up set.
- R8: `irq_o` equals the OR over all bits of (flag AND NOT mask), sampled at the previous edge. This gives one cycle of latency after a flag or mask change.
- R9: `stop_o[n]` and `enable_o[n]` equal bit n of the stop and enable vectors. Flag and mask bits outside n and n+16 for implemented channels always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, 0 when not reading |
| full_evt_i | input | NUM_CH | Full-compare event pulses, one per channel |
| half_evt_i | input | NUM_CH | Half-compare event pulses, one per channel |
| stop_o | output | NUM_CH | Channel halt levels |
| enable_o | output | NUM_CH | Channel enable levels |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
The bench targets these corner cases:

- **Event and software clear on the same flag bit in the same cycle.** A design that let the write win would lose the interrupt.
- **Zero bits in set and clear alias writes.** A design that loaded the alias data would wipe the other channels' bits.
- **Upper half of the flag word.** A design with a wrong half-event offset would raise the wrong bit, or none.
- **Interrupt latency.** The bench checks that `irq_o` rises exactly one cycle after the flag; a combinational or two-stage path would fail this.
- **Reads of aliases and unmapped addresses.** A decoder that aliased unmapped space would return stale vectors.

Random mixed traffic is compared against a bench model on every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LOAD = 2'd1,
    OP_SET  = 2'd2,
    OP_CLR  = 2'd3
  } vec_op_e;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned HALF_OFS = 16;

  // byte offsets: load / set / clear per vector
  localparam int unsigned EN_LD   = 'h00;
  localparam int unsigned EN_ST   = 'h04;
  localparam int unsigned EN_CL   = 'h08;
  localparam int unsigned STOP_LD = 'h0C;
  localparam int unsigned STOP_ST = 'h1C;
  localparam int unsigned STOP_CL = 'h2C;
  localparam int unsigned FLAG_LD = 'h10;
  localparam int unsigned FLAG_ST = 'h14;
  localparam int unsigned FLAG_CL = 'h18;
  localparam int unsigned MASK_LD = 'h20;
  localparam int unsigned MASK_ST = 'h24;
  localparam int unsigned MASK_CL = 'h28;

  function automatic logic [WORD_W-1:0] impl_bits(int unsigned num_ch);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < HALF_OFS; i++) begin
      if (i < num_ch) begin
        m[i]            = 1'b1;
        m[i + HALF_OFS] = 1'b1;
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec
  import tmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output vec_op_e           en_op_o,
  output vec_op_e           stop_op_o,
  output vec_op_e           flag_op_o,
  output vec_op_e           mask_op_o,
  output logic [3:0]        rd_sel_o
);

  function automatic vec_op_e op_of(logic [ADDR_W-1:0] a, int unsigned ld,
                                    int unsigned st, int unsigned cl);
    if (a == ADDR_W'(ld)) return OP_LOAD;
    if (a == ADDR_W'(st)) return OP_SET;
    if (a == ADDR_W'(cl)) return OP_CLR;
    return OP_NONE;
  endfunction

  vec_op_e en_hit, stop_hit, flag_hit, mask_hit;
  logic    wr;

  always_comb begin
    en_hit   = op_of(addr_i, EN_LD, EN_ST, EN_CL);
    stop_hit = op_of(addr_i, STOP_LD, STOP_ST, STOP_CL);
    flag_hit = op_of(addr_i, FLAG_LD, FLAG_ST, FLAG_CL);
    mask_hit = op_of(addr_i, MASK_LD, MASK_ST, MASK_CL);
    wr       = req_i & we_i;

    en_op_o   = wr ? en_hit   : OP_NONE;
    stop_op_o = wr ? stop_hit : OP_NONE;
    flag_op_o = wr ? flag_hit : OP_NONE;
    mask_op_o = wr ? mask_hit : OP_NONE;

    rd_sel_o = {4{req_i & ~we_i}} &
               {mask_hit != OP_NONE, flag_hit != OP_NONE,
                stop_hit != OP_NONE, en_hit != OP_NONE};
  end

endmodule

// File: rtl/tmr_vec_reg.sv
module tmr_vec_reg
  import tmr_pkg::*;
#(
  parameter int unsigned W       = 8,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter logic [W-1:0] KEEP    = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  vec_op_e      op_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] hw_set_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] sw_nxt, nxt;

  always_comb begin
    unique case (op_i)
      OP_LOAD: sw_nxt = wdata_i;
      OP_SET:  sw_nxt = q_o | wdata_i;
      OP_CLR:  sw_nxt = q_o & ~wdata_i;
      default: sw_nxt = q_o;
    endcase
    // hardware set dominates any software update
    nxt = (sw_nxt | hw_set_i) & KEEP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RST_VAL & KEEP;
    else         q_o <= nxt;
  end

endmodule

// File: rtl/tmr_irq_gen.sv
module tmr_irq_gen #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] flag_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(flag_i & ~mask_i);
  end

endmodule

// File: rtl/tmr_ctl_regs.sv
module tmr_ctl_regs
  import tmr_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [NUM_CH-1:0] full_evt_i,
  input  logic [NUM_CH-1:0] half_evt_i,
  output logic [NUM_CH-1:0] stop_o,
  output logic [NUM_CH-1:0] enable_o,
  output logic              irq_o
);

  localparam logic [WORD_W-1:0] IRQ_BITS = impl_bits(NUM_CH);

  vec_op_e           en_op, stop_op, flag_op, mask_op;
  logic [3:0]        rd_sel;
  logic [WORD_W-1:0] flag_q, mask_q, flag_hw;

  tmr_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .en_op_o  (en_op),
    .stop_op_o(stop_op),
    .flag_op_o(flag_op),
    .mask_op_o(mask_op),
    .rd_sel_o (rd_sel)
  );

  always_comb begin
    flag_hw = '0;
    for (int unsigned n = 0; n < NUM_CH; n++) begin
      flag_hw[n]            = full_evt_i[n];
      flag_hw[n + HALF_OFS] = half_evt_i[n];
    end
  end

  tmr_vec_reg #(.W(NUM_CH), .RST_VAL('0)) u_en (
    .clk_i, .rst_ni, .op_i(en_op), .wdata_i(wdata_i[NUM_CH-1:0]),
    .hw_set_i('0), .q_o(enable_o)
  );

  tmr_vec_reg #(.W(NUM_CH), .RST_VAL('1)) u_stop (
    .clk_i, .rst_ni, .op_i(stop_op), .wdata_i(wdata_i[NUM_CH-1:0]),
    .hw_set_i('0), .q_o(stop_o)
  );

  tmr_vec_reg #(.W(WORD_W), .RST_VAL('0), .KEEP(IRQ_BITS)) u_flag (
    .clk_i, .rst_ni, .op_i(flag_op), .wdata_i(wdata_i),
    .hw_set_i(flag_hw), .q_o(flag_q)
  );

  tmr_vec_reg #(.W(WORD_W), .RST_VAL('1), .KEEP(IRQ_BITS)) u_mask (
    .clk_i, .rst_ni, .op_i(mask_op), .wdata_i(wdata_i),
    .hw_set_i('0), .q_o(mask_q)
  );

  tmr_irq_gen #(.W(WORD_W)) u_irq (
    .clk_i, .rst_ni, .flag_i(flag_q), .mask_i(mask_q), .irq_o(irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_sel[0]) rdata_o = WORD_W'(enable_o);
    if (rd_sel[1]) rdata_o = WORD_W'(stop_o);
    if (rd_sel[2]) rdata_o = flag_q;
    if (rd_sel[3]) rdata_o = mask_q;
  end

endmodule

// File: rtl/tmr_ctl_regs_chk.sv
module tmr_ctl_regs_chk #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic [NUM_CH-1:0] full_evt_i,
  input logic [NUM_CH-1:0] half_evt_i,
  input logic [NUM_CH-1:0] stop_o,
  input logic [NUM_CH-1:0] enable_o,
  input logic              irq_o,
  input logic [31:0]       flag_q,
  input logic [31:0]       mask_q
);

  logic mapped, wr;
  always_comb begin
    wr     = req_i & we_i;
    mapped = addr_i inside {ADDR_W'('h00), ADDR_W'('h04), ADDR_W'('h08),
                            ADDR_W'('h0C), ADDR_W'('h1C), ADDR_W'('h2C),
                            ADDR_W'('h10), ADDR_W'('h14), ADDR_W'('h18),
                            ADDR_W'('h20), ADDR_W'('h24), ADDR_W'('h28)};
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    AST_FULL_EVT_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      full_evt_i[n] |=> flag_q[n]); // R6
    AST_HALF_EVT_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      half_evt_i[n] |=> flag_q[n+16]); // R6
    AST_EVT_BEATS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (full_evt_i[n] && wr && addr_i == ADDR_W'('h18) && wdata_i[n]) |=> flag_q[n]); // R7
  end

  AST_IRQ_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == $past(|(flag_q & ~mask_q))); // R8

  AST_EN_SET_ALIAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == ADDR_W'('h04)) |=>
      (enable_o & $past(wdata_i[NUM_CH-1:0])) == $past(wdata_i[NUM_CH-1:0])); // R3

  AST_STOP_CLR_ALIAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == ADDR_W'('h2C)) |=>
      (stop_o & $past(wdata_i[NUM_CH-1:0])) == '0); // R4

  AST_UNMAPPED_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !mapped) |-> rdata_o == 32'h0); // R5

endmodule

bind tmr_ctl_regs tmr_ctl_regs_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .full_evt_i(full_evt_i),
  .half_evt_i(half_evt_i), .stop_o(stop_o), .enable_o(enable_o),
  .irq_o(irq_o), .flag_q(flag_q), .mask_q(mask_q)
);

// File: tb/tb_tmr_ctl_regs.sv
module tb_tmr_ctl_regs;

  localparam int unsigned NCH = 8;
  localparam logic [31:0] IMPL = 32'h00FF00FF;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NCH-1:0] full_evt = '0, half_evt = '0;
  logic [NCH-1:0] stop, en;
  logic       irq;

  int unsigned checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  logic [7:0]  en_m, stop_m;
  logic [31:0] flag_m, mask_m;
  logic        irq_m;

  always #4 clk = ~clk;

  tmr_ctl_regs #(.NUM_CH(NCH), .ADDR_W(8)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .full_evt_i(full_evt),
    .half_evt_i(half_evt), .stop_o(stop), .enable_o(en), .irq_o(irq)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h00, 8'h04, 8'h08: return {24'h0, en_m};
      8'h0C, 8'h1C, 8'h2C: return {24'h0, stop_m};
      8'h10, 8'h14, 8'h18: return flag_m;
      8'h20, 8'h24, 8'h28: return mask_m;
      default:             return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] upd(input logic [31:0] cur, input logic [7:0] a,
                                      input logic [7:0] ld, input logic [7:0] st,
                                      input logic [7:0] cl, input logic [31:0] d);
    if (a == ld) return d;
    if (a == st) return cur | d;
    if (a == cl) return cur & ~d;
    return cur;
  endfunction

  // one bus cycle; read data checked before the edge, outputs after it
  task automatic step(input logic r, input logic w, input logic [7:0] a,
                      input logic [31:0] d, input logic [7:0] fe, input logic [7:0] he);
    logic [31:0] en_n, stop_n, flag_n, mask_n;
    logic irq_n;
    @(negedge clk);
    req = r; we = w; addr = a; wdata = d; full_evt = fe; half_evt = he;
    #1;
    if (r && !w) chk(rdata == exp_rd(a), "R5 read data", rdata, exp_rd(a));
    irq_n  = |(flag_m & ~mask_m);
    en_n   = {24'h0, en_m};
    stop_n = {24'h0, stop_m};
    flag_n = flag_m;
    mask_n = mask_m;
    if (r && w) begin
      en_n   = upd(en_n, a, 8'h00, 8'h04, 8'h08, d);
      stop_n = upd(stop_n, a, 8'h0C, 8'h1C, 8'h2C, d);
      flag_n = upd(flag_n, a, 8'h10, 8'h14, 8'h18, d);
      mask_n = upd(mask_n, a, 8'h20, 8'h24, 8'h28, d);
    end
    flag_n = (flag_n | {8'h0, he, 8'h0, fe}) & IMPL;
    mask_n = mask_n & IMPL;
    @(posedge clk);
    en_m = en_n[7:0]; stop_m = stop_n[7:0]; flag_m = flag_n; mask_m = mask_n;
    irq_m = irq_n;
    #2;
    chk(en == en_m, "R9 enable_o", {24'h0, en}, {24'h0, en_m});
    chk(stop == stop_m, "R9 stop_o", {24'h0, stop}, {24'h0, stop_m});
    chk(irq == irq_m, "R8 irq_o", {31'h0, irq}, {31'h0, irq_m});
    req = 1'b0; we = 1'b0; full_evt = '0; half_evt = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(1'b1, 1'b1, a, d, 8'h0, 8'h0);
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1;
    chk(rdata == e, tag, rdata, e);
    @(posedge clk);
    #2;
    req = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] addrs [15];
    void'($urandom(32'h1D2C3B4A));
    addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h1C, 8'h2C, 8'h10, 8'h14, 8'h18,
              8'h20, 8'h24, 8'h28, 8'h30, 8'h3C, 8'h02};
    en_m = '0; stop_m = 8'hFF; flag_m = '0; mask_m = IMPL; irq_m = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 reset state
    chk(stop == 8'hFF && en == 8'h00 && irq == 1'b0, "R1 reset ports",
        {stop, en, 15'h0, irq}, {8'hFF, 8'h00, 16'h0});
    rd_exp(8'h20, 32'h00FF00FF, "R1 mask reset");
    rd_exp(8'h10, 32'h0, "R1 flag reset");
    rd_exp(8'h0C, 32'hFF, "R1 stop reset");
    rd_exp(8'h30, 32'h0, "R5 unmapped read");

    // R2 load, R3 set, R4 clear
    wr(8'h00, 32'hA5);       rd_exp(8'h04, 32'hA5, "R2 enable load, R5 alias read");
    wr(8'h04, 32'h02);       rd_exp(8'h00, 32'hA7, "R3 enable set alias");
    wr(8'h08, 32'h21);       rd_exp(8'h08, 32'h86, "R4 enable clear alias");
    wr(8'h2C, 32'h0F);       rd_exp(8'h1C, 32'hF0, "R4 stop clear alias");
    wr(8'h1C, 32'h01);       rd_exp(8'h0C, 32'hF1, "R3 stop set alias");
    wr(8'h10, 32'hFFFFFFFF); rd_exp(8'h10, 32'h00FF00FF, "R9 flag implemented bits");
    wr(8'h18, 32'hFFFFFFFF); rd_exp(8'h14, 32'h0, "R4 flag clear alias");
    wr(8'h30, 32'hFFFFFFFF); rd_exp(8'h00, 32'h86, "R5 unmapped write ignored");

    // R6 half event lands at bit n+16
    step(1'b0, 1'b0, 8'h0, 32'h0, 8'h00, 8'h08);
    rd_exp(8'h10, 32'h0008_0000, "R6 half event bit 19");
    // R7 event beats clear in same cycle
    step(1'b1, 1'b1, 8'h18, 32'h000F_0004, 8'h04, 8'h00);
    rd_exp(8'h10, 32'h0000_0004, "R7 event wins over clear");
    step(1'b1, 1'b1, 8'h10, 32'h0, 8'h00, 8'h01);
    rd_exp(8'h18, 32'h0001_0000, "R7 event wins over load");
    wr(8'h18, 32'hFFFFFFFF);

    // R8 irq latency: unmask bit 0, raise event
    wr(8'h28, 32'h1);
    @(negedge clk);
    full_evt = 8'h01;
    @(posedge clk); #2 full_evt = '0;
    chk(irq == 1'b0, "R8 irq not yet", {31'h0, irq}, 32'h0);
    @(posedge clk); #2;
    chk(irq == 1'b1, "R8 irq one cycle later", {31'h0, irq}, 32'h1);
    flag_m = 32'h1; irq_m = 1'b1;
    wr(8'h24, 32'h1);
    chk(irq == 1'b1, "R8 mask takes a cycle", {31'h0, irq}, 32'h1);
    step(1'b0, 1'b0, 8'h0, 32'h0, 8'h0, 8'h0);
    chk(irq == 1'b0, "R8 irq cleared by mask", {31'h0, irq}, 32'h0);

    // random mixed traffic
    for (int i = 0; i < 2000; i++) begin
      logic [7:0] a;
      logic [31:0] d;
      a = addrs[$urandom_range(0, 14)];
      d = $urandom();
      if ($urandom_range(0, 3) == 0) d = 32'h1 << $urandom_range(0, 31);
      step(1'b1, ($urandom_range(0, 1) == 1), a, d,
           ($urandom_range(0, 3) == 0) ? 8'($urandom()) : 8'h0,
           ($urandom_range(0, 3) == 0) ? 8'($urandom()) : 8'h0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule